// File: doc/BRIEF.md
# Prescaled 16-bit Timer/Counter

This peripheral is a 16-bit up-counter that a processor reaches over an 8-bit register bus. It can advance from one of two sources. The first is an internal tick that occurs once every fourth system clock. The second is the rising edges of an external clock input, which can be taken through a two-flop synchronizer or straight from a single sampling flop. A two-bit prescaler divides the chosen source by 1, 2, 4 or 8, and an enable bit starts and stops counting.

Each counter byte has its own bus address. An optional paired-byte mode keeps a buffer for the high byte. Software reads the low byte first, which captures the high byte at that moment. For writes, software writes the high byte first, and a later low-byte write loads both bytes in one cycle.

A wrap from all ones to zero sets a sticky interrupt flag, and software clears the flag by writing 0 to it. A one-cycle clear pulse from a compare unit zeroes the count.

Top module: `prescaled_timer16`

## Requirements
- R1: After reset the count, the high-byte buffer, the control register (address 2) and the flag (address 3, bit 0) all read 0, and `irqFlag` is low.
- R2: When control bit 1 is 0 and bit 0 (enable) is 1 with a prescale of 0, the count advances exactly once per 4 system clocks.
- R3: The prescale field, control bits [4:3] = p, makes the count advance once per 2^p source ticks.
- R4: When control bit 1 is 1, each rising edge of `extClk` is one source tick. This holds with control bit 2 at 1 (synchronized) and at 0 (unsynchronized).
- R5: At prescale 0, a rise of `extClk` before clock edge A shows in the count after edge A+1 in the unsynchronized mode and after edge A+2 in the synchronized mode.
- R6: While control bit 0 is 0, the count holds its value whatever the source does.
- R7: With control bit 7 = 1, a read of address 0 copies the live high byte into the buffer, and reads of address 1 return the buffer.
- R8: With control bit 7 = 1, a write to address 1 fills only the buffer, and a write to address 0 loads {buffer, data} into the count in one cycle.
- R9: With control bit 7 = 0, writes to address 0 and address 1 replace only the low byte or only the high byte of the count.
- R10: A wrap from 0xFFFF to 0x0000 sets the flag. Writing 0 to address 3 bit 0 clears the flag, and writing 1 does not change it.
- R11: A wrap that happens in the same cycle as a flag-clear write leaves the flag set.
- R12: A pulse on `evtClr` zeroes the count at the next edge, whether or not the enable bit is set. It wins over a count write in the same cycle.
- R13: A count write, an `evtClr` pulse or a control write restarts the prescaler, so the next full division period starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 2 | Register select: 0 count low, 1 count high, 2 control, 3 flag |
| busWr | input | 1 | Write strobe, committed at the clock edge |
| busRd | input | 1 | Read strobe; a read of address 0 can capture the high byte |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for `busAddr`, combinational |
| extClk | input | 1 | External count input |
| evtClr | input | 1 | Clear pulse from the compare unit |
| irqFlag | output | 1 | Sticky overflow flag |

## Verification
Internal-source counting is measured over exact windows of 4·2^p·M clocks, which separates a wrong tick period from a wrong prescale ratio. External edge trains use random pulse widths, random prescale values and both synchronizer settings. The expected count is the edge total shifted right by p, so a lost edge or a double count shows up. Directed cases cover the remaining behaviour:
- a single edge watched cycle by cycle, which separates the one-flop path from the two-flop path;
- byte-access sequences that separate live reads from buffered reads and separate split writes from paired writes;
- same-cycle collisions of a wrap with a flag clear;
- same-cycle collisions of a trigger with a count write;
- partial prescaler periods cut off by a write or a trigger.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

  typedef enum logic [1:0] {
    ADDR_CNT_LO = 2'd0,
    ADDR_CNT_HI = 2'd1,
    ADDR_CTRL   = 2'd2,
    ADDR_FLAG   = 2'd3
  } tmrAddr_e;

  // control register bit positions
  localparam int CTL_EN     = 0;
  localparam int CTL_SRC    = 1;
  localparam int CTL_SYNC   = 2;
  localparam int CTL_PS_LO  = 3;
  localparam int CTL_MODE16 = 7;
  localparam logic [7:0] CTL_MASK = 8'b1001_1111;

  // strobes from control to datapath
  typedef struct packed {
    logic incTick;
    logic clrCnt;
    logic wrLo;
    logic wrHi;
    logic mode16;
    logic capHi;
    logic flagClr;
  } tmrStrobe_t;

endpackage

// File: rtl/tmr16_ctrl.sv
module tmr16_ctrl
  import tmr16_pkg::*;
#(
  parameter int BUS_W       = 8,
  parameter int PS_W        = 2,
  parameter int INT_DIV     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       busAddr,
  input  logic             busWr,
  input  logic             busRd,
  input  logic [BUS_W-1:0] busWdata,
  input  logic             extClk,
  input  logic             evtClr,
  output logic [BUS_W-1:0] ctrlQ,
  output tmrStrobe_t       strobe
);

  localparam int PH_W  = (INT_DIV > 1) ? $clog2(INT_DIV) : 1;
  localparam int PSC_W = (1 << PS_W) - 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(INT_DIV - 1);

  logic [PH_W-1:0]        phaseQ;
  logic                   intTick;
  logic [SYNC_STAGES:0]   samp;
  logic                   edgeAsync;
  logic                   edgeSync;
  logic                   extTick;
  logic                   srcTick;
  logic [PS_W-1:0]        psSel;
  logic [PSC_W-1:0]       psCnt;
  logic [PSC_W-1:0]       psLimit;
  logic                   psLast;
  logic                   psClear;
  logic                   ctrlWr;
  logic                   cntWr;
  logic                   incTick;
  tmrAddr_e               addr;

  assign addr   = tmrAddr_e'(busAddr);
  assign ctrlWr = busWr && (addr == ADDR_CTRL);
  assign cntWr  = busWr && ((addr == ADDR_CNT_LO) ||
                            ((addr == ADDR_CNT_HI) && !ctrlQ[CTL_MODE16]));

  // control register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       ctrlQ <= '0;
    else if (ctrlWr) ctrlQ <= busWdata & BUS_W'(CTL_MASK);
  end

  // internal instruction-rate tick: one pulse every INT_DIV clocks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                phaseQ <= '0;
    else if (phaseQ == PH_LAST) phaseQ <= '0;
    else                      phaseQ <= phaseQ + 1'b1;
  end
  assign intTick = (phaseQ == PH_LAST);

  // sampling chain for the external input
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) samp <= '0;
    else       samp <= {samp[SYNC_STAGES-1:0], extClk};
  end
  assign edgeAsync = samp[0] && !samp[1];
  assign edgeSync  = samp[SYNC_STAGES-1] && !samp[SYNC_STAGES];
  assign extTick   = ctrlQ[CTL_SYNC] ? edgeSync : edgeAsync;
  assign srcTick   = ctrlQ[CTL_SRC] ? extTick : intTick;

  // prescaler
  assign psSel   = ctrlQ[CTL_PS_LO +: PS_W];
  assign psLimit = PSC_W'((1 << psSel) - 1);
  assign psLast  = (psCnt == psLimit);
  assign psClear = evtClr || cntWr || ctrlWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          psCnt <= '0;
    else if (psClear)                   psCnt <= '0;
    else if (ctrlQ[CTL_EN] && srcTick)  psCnt <= psLast ? '0 : psCnt + 1'b1;
  end

  assign incTick = ctrlQ[CTL_EN] && srcTick && psLast;

  always_comb begin
    strobe.incTick = incTick;
    strobe.clrCnt  = evtClr;
    strobe.wrLo    = busWr && (addr == ADDR_CNT_LO);
    strobe.wrHi    = busWr && (addr == ADDR_CNT_HI);
    strobe.mode16  = ctrlQ[CTL_MODE16];
    strobe.capHi   = busRd && (addr == ADDR_CNT_LO) && ctrlQ[CTL_MODE16];
    strobe.flagClr = busWr && (addr == ADDR_FLAG) && !busWdata[0];
  end

  // R2: internal ticks never come back to back
  a_r2_int_gap: assert property (@(posedge clk) disable iff (!rstN)
    (incTick && !ctrlQ[CTL_SRC] && !ctrlWr) |=> !incTick);

  // R3: prescaler count never passes the selected limit
  a_r3_ps_range: assert property (@(posedge clk) disable iff (!rstN)
    psCnt <= psLimit);

  // R13: a restart leaves the prescaler at zero
  a_r13_ps_restart: assert property (@(posedge clk) disable iff (!rstN)
    psClear |=> (psCnt == '0));

endmodule

// File: rtl/tmr16_dp.sv
module tmr16_dp
  import tmr16_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  tmrStrobe_t         strb,
  input  logic [BUS_W-1:0]   wdata,
  output logic [2*BUS_W-1:0] cntQ,
  output logic [BUS_W-1:0]   hiBufQ,
  output logic               flagQ
);

  localparam int CNT_W = 2 * BUS_W;

  logic [CNT_W-1:0] cntNext;
  logic             loadHit;
  logic             ovf;

  assign loadHit = strb.wrLo || (strb.wrHi && !strb.mode16);

  always_comb begin
    cntNext = cntQ;
    if (strb.clrCnt) begin
      cntNext = '0;
    end else if (strb.wrLo) begin
      cntNext = strb.mode16 ? {hiBufQ, wdata} : {cntQ[CNT_W-1:BUS_W], wdata};
    end else if (strb.wrHi && !strb.mode16) begin
      cntNext = {wdata, cntQ[BUS_W-1:0]};
    end else if (strb.incTick) begin
      cntNext = cntQ + 1'b1;
    end
  end

  assign ovf = strb.incTick && (&cntQ) && !strb.clrCnt && !loadHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ   <= '0;
      hiBufQ <= '0;
      flagQ  <= 1'b0;
    end else begin
      cntQ <= cntNext;
      if (strb.wrHi && strb.mode16) hiBufQ <= wdata;
      else if (strb.capHi)          hiBufQ <= cntQ[CNT_W-1:BUS_W];
      if (ovf)               flagQ <= 1'b1;
      else if (strb.flagClr) flagQ <= 1'b0;
    end
  end

  // R12: a trigger leaves a zero count
  a_r12_trig_clear: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrCnt |=> (cntQ == '0));

  // R10: a wrap raises the flag
  a_r10_wrap_flag: assert property (@(posedge clk) disable iff (!rstN)
    (strb.incTick && (cntQ == '1) && !strb.clrCnt && !strb.wrLo && !strb.wrHi)
      |=> flagQ);

  // R11: a clear with no wrap drops the flag
  a_r11_flag_clear: assert property (@(posedge clk) disable iff (!rstN)
    (strb.flagClr && !strb.incTick) |=> !flagQ);

  // R6: without a tick or a load the count is frozen
  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.incTick && !strb.clrCnt && !strb.wrLo && !strb.wrHi) |=> $stable(cntQ));

endmodule

// File: rtl/prescaled_timer16.sv
module prescaled_timer16
  import tmr16_pkg::*;
#(
  parameter int BUS_W       = 8,
  parameter int PS_W        = 2,
  parameter int INT_DIV     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       busAddr,
  input  logic             busWr,
  input  logic             busRd,
  input  logic [BUS_W-1:0] busWdata,
  output logic [BUS_W-1:0] busRdata,
  input  logic             extClk,
  input  logic             evtClr,
  output logic             irqFlag
);

  localparam int CNT_W = 2 * BUS_W;

  tmrStrobe_t       strobe;
  logic [BUS_W-1:0] ctrlQ;
  logic [CNT_W-1:0] cntQ;
  logic [BUS_W-1:0] hiBufQ;
  logic             flagQ;

  tmr16_ctrl #(
    .BUS_W(BUS_W), .PS_W(PS_W), .INT_DIV(INT_DIV), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .extClk(extClk), .evtClr(evtClr),
    .ctrlQ(ctrlQ), .strobe(strobe)
  );

  tmr16_dp #(.BUS_W(BUS_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strobe), .wdata(busWdata),
    .cntQ(cntQ), .hiBufQ(hiBufQ), .flagQ(flagQ)
  );

  always_comb begin
    unique case (tmrAddr_e'(busAddr))
      ADDR_CNT_LO: busRdata = cntQ[BUS_W-1:0];
      ADDR_CNT_HI: busRdata = ctrlQ[CTL_MODE16] ? hiBufQ : cntQ[CNT_W-1:BUS_W];
      ADDR_CTRL:   busRdata = ctrlQ;
      default:     busRdata = {{(BUS_W-1){1'b0}}, flagQ};
    endcase
  end

  assign irqFlag = flagQ;

endmodule

// File: tb/sim_prescaled_timer16.sv
`timescale 1ns/1ps
module sim_prescaled_timer16;

  localparam logic [7:0] EN = 8'h01, SRC = 8'h02, SYN = 8'h04, M16 = 8'h80;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic       extClk = 1'b0;
  logic       evtClr = 1'b0;
  logic       irqFlag;

  int checks = 0;
  int failures = 0;

  prescaled_timer16 u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .extClk(extClk),
    .evtClr(evtClr), .irqFlag(irqFlag)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic rdCount(output logic [15:0] c);
    logic [7:0] lo, hi;
    rdReg(2'd0, lo);
    rdReg(2'd1, hi);
    c = {hi, lo};
  endtask

  task automatic pulseExt(input int hi, input int lo);
    extClk = 1'b1;
    repeat (hi) @(negedge clk);
    extClk = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  function automatic int expDiv(input int ticks, input int ps);
    return ticks >> ps;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0]  d;
    logic [15:0] c;
    int unsigned seed;
    seed = $urandom(1234);
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rdReg(2'd0, d); chk("R1 count low", d, 8'h00);
    rdReg(2'd1, d); chk("R1 count high", d, 8'h00);
    rdReg(2'd2, d); chk("R1 control", d, 8'h00);
    rdReg(2'd3, d); chk("R1 flag reg", d, 8'h00);
    chk("R1 irqFlag", irqFlag, 1'b0);

    // R2/R3 internal source over exact windows
    for (int i = 0; i < 12; i++) begin
      int ps = $urandom % 4;
      int m  = 1 + $urandom % 5;
      int w  = 4 * (1 << ps) * m;
      if (i == 0) begin ps = 0; m = 3; w = 12; end
      wrReg(2'd2, 8'h00);
      wrReg(2'd0, 8'h00);
      wrReg(2'd1, 8'h00);
      wrReg(2'd2, EN | 8'(ps << 3));
      repeat (w - 2) @(negedge clk);
      wrReg(2'd2, 8'h00);
      rdCount(c);
      chk($sformatf("R2 R3 internal ps=%0d", ps), c, 16'(m));
    end

    // R4/R3 external edge trains, both sampling modes
    for (int i = 0; i < 16; i++) begin
      int ps = $urandom % 4;
      int sy = $urandom % 2;
      int n  = 1 + $urandom % 20;
      wrReg(2'd2, 8'h00);
      wrReg(2'd0, 8'h00);
      wrReg(2'd1, 8'h00);
      wrReg(2'd2, EN | SRC | (sy ? SYN : 8'h00) | 8'(ps << 3));
      for (int k = 0; k < n; k++) pulseExt(1 + $urandom % 3, 1 + $urandom % 3);
      repeat (4) @(negedge clk);
      wrReg(2'd2, 8'h00);
      rdCount(c);
      chk($sformatf("R4 R3 external sync=%0d ps=%0d n=%0d", sy, ps, n), c, 16'(expDiv(n, ps)));
    end

    // R5 latency, unsynchronized then synchronized
    for (int sy = 0; sy < 2; sy++) begin
      wrReg(2'd0, 8'h00);
      wrReg(2'd1, 8'h00);
      wrReg(2'd2, EN | SRC | (sy ? SYN : 8'h00));
      busAddr = 2'd0;
      @(negedge clk);
      extClk = 1'b1;
      @(negedge clk); #1 chk("R5 after edge A", busRdata, 8'h00);
      @(negedge clk); #1 chk("R5 after edge A+1", busRdata, sy ? 8'h00 : 8'h01);
      @(negedge clk); #1 chk("R5 after edge A+2", busRdata, 8'h01);
      extClk = 1'b0;
      repeat (3) @(negedge clk);
    end

    // R6 enable low holds the count
    wrReg(2'd2, 8'h00);
    wrReg(2'd0, 8'h42);
    wrReg(2'd1, 8'h07);
    wrReg(2'd2, SRC);
    for (int k = 0; k < 5; k++) pulseExt(2, 2);
    rdCount(c); chk("R6 ext while disabled", c, 16'h0742);
    wrReg(2'd2, 8'h00);
    repeat (40) @(negedge clk);
    rdCount(c); chk("R6 internal while disabled", c, 16'h0742);

    // R9 byte writes in split mode
    wrReg(2'd1, 8'h34);
    wrReg(2'd0, 8'h56);
    rdCount(c); chk("R9 both bytes", c, 16'h3456);
    wrReg(2'd1, 8'h99);
    rdCount(c); chk("R9 high only", c, 16'h9956);

    // R7 paired read captures high byte
    wrReg(2'd2, M16);
    rdReg(2'd0, d); chk("R7 low read", d, 8'h56);
    wrReg(2'd2, 8'h00);
    wrReg(2'd1, 8'h11);
    wrReg(2'd2, M16);
    rdReg(2'd1, d); chk("R7 buffered high", d, 8'h99);
    wrReg(2'd2, 8'h00);
    rdReg(2'd1, d); chk("R7 live high", d, 8'h11);

    // R8 paired write
    wrReg(2'd2, M16);
    wrReg(2'd1, 8'hAB);
    wrReg(2'd2, 8'h00);
    rdCount(c); chk("R8 high write only buffered", c, 16'h1156);
    wrReg(2'd2, M16);
    wrReg(2'd0, 8'hCD);
    wrReg(2'd2, 8'h00);
    rdCount(c); chk("R8 paired load", c, 16'hABCD);

    // R10 wrap sets flag
    wrReg(2'd1, 8'hFF);
    wrReg(2'd0, 8'hFF);
    wrReg(2'd3, 8'h01);
    rdReg(2'd3, d); chk("R10 write one does not set", d, 8'h00);
    wrReg(2'd2, EN | SRC);
    pulseExt(2, 3);
    chk("R10 irqFlag after wrap", irqFlag, 1'b1);
    rdCount(c); chk("R10 count wrapped", c, 16'h0000);
    wrReg(2'd3, 8'h01);
    rdReg(2'd3, d); chk("R10 write one keeps flag", d, 8'h01);

    // R11 wrap and clear in the same cycle
    wrReg(2'd1, 8'hFF);
    wrReg(2'd0, 8'hFF);
    @(negedge clk);
    extClk = 1'b1;
    @(negedge clk);
    busAddr = 2'd3; busWdata = 8'h00; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
    chk("R11 flag kept", irqFlag, 1'b1);
    extClk = 1'b0;
    repeat (2) @(negedge clk);
    rdCount(c); chk("R11 count wrapped", c, 16'h0000);
    wrReg(2'd3, 8'h00);
    chk("R10 clear by zero", irqFlag, 1'b0);

    // R12 trigger beats a write, works while disabled
    wrReg(2'd2, 8'h00);
    wrReg(2'd1, 8'h12);
    wrReg(2'd0, 8'h34);
    @(negedge clk);
    busAddr = 2'd0; busWdata = 8'h77; busWr = 1'b1; evtClr = 1'b1;
    @(negedge clk);
    busWr = 1'b0; evtClr = 1'b0;
    rdCount(c); chk("R12 trigger over write", c, 16'h0000);

    // R13 prescaler restart by trigger and by count write
    wrReg(2'd2, EN | SRC | 8'(3 << 3));
    for (int k = 0; k < 5; k++) pulseExt(2, 2);
    @(negedge clk); evtClr = 1'b1; @(negedge clk); evtClr = 1'b0;
    for (int k = 0; k < 3; k++) pulseExt(2, 2);
    rdCount(c); chk("R13 trigger restarts prescaler", c, 16'h0000);
    for (int k = 0; k < 5; k++) pulseExt(2, 2);
    rdCount(c); chk("R13 full period after trigger", c, 16'h0001);
    for (int k = 0; k < 5; k++) pulseExt(2, 2);
    wrReg(2'd0, 8'h00);
    for (int k = 0; k < 3; k++) pulseExt(2, 2);
    rdCount(c); chk("R13 write restarts prescaler", c, 16'h0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule